// File: doc/BRIEF.md
# Pipelined Dot-Product Reducer

This block forms the scalar dot product of two integer vectors, one element pair per clock, in the way a single entry of a matrix product is built. Each accepted pair enters a ten-stage multiply pipeline. The product then goes straight into a four-stage add pipeline that closes on itself, so that four partial sums rotate through it. No register file sits between the two pipelines. The whole N-element reduction is issued as one operation, with no separate multiply and add steps per element.

A producer presents `in_a`/`in_b` with `in_valid`, and marks the final pair of a vector with `in_last`. A pair is taken on every clock edge where `in_valid` and `in_ready` are both high, and idle cycles inside a vector are allowed. After the last pair is taken, `in_ready` drops. The partial sums then drain through both pipelines and are folded into one 64-bit total. That total appears on `res_data` with a one-cycle `res_valid` pulse, and `in_ready` returns in that same cycle, so the next vector can begin.

Top module: `vmac_reducer`

## Requirements
- R1: During and after reset, `res_valid` is 0, `res_data` is 0 and `in_ready` is 1. A reset in the middle of a vector discards every partial sum.
- R2: The result is the sum of signed(in_a)*signed(in_b) over all accepted pairs of the vector, sign-extended to 64 bits and wrapped modulo 2^64.
- R3: A pair is accepted on each rising edge where `in_valid` and `in_ready` are both 1, so vectors stream at one pair per clock. Cycles inside a vector with `in_valid` low add nothing.
- R4: `res_valid` rises exactly MUL_STAGES+ADD_STAGES+1 (15 by default) clock edges after the edge that accepted the pair marked `in_last`. It stays high for exactly one cycle.
- R5: `in_ready` is 0 from the cycle after the last pair is accepted until the cycle in which `res_valid` is 1. It is 1 in that cycle.
- R6: Pairs presented with `in_valid` high while `in_ready` is 0 are ignored, whatever their data and `in_last` values.
- R7: `res_data` keeps its value in every cycle where `res_valid` is 0.
- R8: A vector whose first pair carries `in_last` gives that single product. Extreme operands such as (-2^31)*(-2^31) give the exact 64-bit product.
- R9: Each vector starts from a zero sum. Nothing from an earlier vector leaks into a later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element pair present |
| in_last | input | 1 | Pair closes the current vector |
| in_a | input | 32 | Element of the first vector, signed |
| in_b | input | 32 | Element of the second vector, signed |
| in_ready | output | 1 | Block can take a pair this cycle |
| res_valid | output | 1 | One-cycle pulse: result available |
| res_data | output | 64 | Signed dot-product result |

## Verification
The only timed result is the sum. It is due 15 edges after the edge that took the last pair: ten multiply stages, four add stages and the output register. The bench drives inputs on falling edges and counts falling edges from that accept edge. At every count from 1 to 18 it checks `res_valid`, and it expects the pulse only at count 15. At that count it also compares `res_data` and checks that `in_ready` has returned. At count 16 it confirms that the value is held. A checker module counts the same window with its own counter, and it keeps its own running sum of the accepted pairs to compare against the result.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
   typedef enum logic {
      ST_FILL  = 1'b0,
      ST_DRAIN = 1'b1
   } vmac_state_e;

   function automatic int vmac_latency(input int mul_stages, input int add_stages);
      return mul_stages + add_stages + 1;
   endfunction
endpackage

// File: rtl/vmac_mul_pipe.sv
module vmac_mul_pipe #(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 64,
   parameter int STAGES = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_fire,
   input  logic                     in_last,
   input  logic signed [DATA_W-1:0] in_a,
   input  logic signed [DATA_W-1:0] in_b,
   output logic                     out_valid,
   output logic                     out_last,
   output logic signed [ACC_W-1:0]  out_prod
);
   localparam int PROD_W = 2 * DATA_W;

   logic [STAGES-1:0]        vld_q;
   logic [STAGES-1:0]        lst_q;
   logic signed [ACC_W-1:0]  prod_q [STAGES];
   logic signed [PROD_W-1:0] raw_prod;

   assign raw_prod = in_a * in_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q[0]  <= 1'b0;
         lst_q[0]  <= 1'b0;
         prod_q[0] <= '0;
      end else begin
         vld_q[0]  <= in_fire;
         lst_q[0]  <= in_fire & in_last;
         prod_q[0] <= ACC_W'(raw_prod);
      end
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[g]  <= 1'b0;
            lst_q[g]  <= 1'b0;
            prod_q[g] <= '0;
         end else begin
            vld_q[g]  <= vld_q[g-1];
            lst_q[g]  <= lst_q[g-1];
            prod_q[g] <= prod_q[g-1];
         end
      end
   end

   assign out_valid = vld_q[STAGES-1];
   assign out_last  = lst_q[STAGES-1];
   assign out_prod  = prod_q[STAGES-1];
endmodule

// File: rtl/vmac_add_ring.sv
module vmac_add_ring #(
   parameter int ACC_W  = 64,
   parameter int STAGES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      in_valid,
   input  logic                      in_last,
   input  logic signed [ACC_W-1:0]   in_prod,
   output logic [ACC_W*STAGES-1:0]   slots_flat,
   output logic                      done
);
   logic signed [ACC_W-1:0] slot_q [STAGES];
   logic [STAGES-1:0]       mark_q;
   logic signed [ACC_W-1:0] addend;

   assign addend = in_valid ? in_prod : '0;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         slot_q[0] <= '0;
         mark_q[0] <= 1'b0;
      end else begin
         slot_q[0] <= slot_q[STAGES-1] + addend;
         mark_q[0] <= in_valid & in_last;
      end
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            slot_q[g] <= '0;
            mark_q[g] <= 1'b0;
         end else begin
            slot_q[g] <= slot_q[g-1];
            mark_q[g] <= mark_q[g-1];
         end
      end
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_flat
      assign slots_flat[g*ACC_W +: ACC_W] = slot_q[g];
   end

   assign done = mark_q[STAGES-1];
endmodule

// File: rtl/vmac_reduce.sv
module vmac_reduce #(
   parameter int ACC_W = 64,
   parameter int LANES = 4
) (
   input  logic [ACC_W*LANES-1:0] slots_flat,
   output logic [ACC_W-1:0]       total
);
   always_comb begin
      total = '0;
      for (int i = 0; i < LANES; i++) begin
         total = total + slots_flat[i*ACC_W +: ACC_W];
      end
   end
endmodule

// File: rtl/vmac_reducer.sv
module vmac_reducer
   import vmac_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ACC_W      = 64,
   parameter int MUL_STAGES = 10,
   parameter int ADD_STAGES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_last,
   input  logic signed [DATA_W-1:0] in_a,
   input  logic signed [DATA_W-1:0] in_b,
   output logic                     in_ready,
   output logic                     res_valid,
   output logic signed [ACC_W-1:0]  res_data
);
   if (MUL_STAGES < 1) begin : g_bad_mul
      $error("vmac_reducer: MUL_STAGES must be at least 1");
   end
   if (ADD_STAGES < 1) begin : g_bad_add
      $error("vmac_reducer: ADD_STAGES must be at least 1");
   end
   if (ACC_W < 2 * DATA_W) begin : g_bad_acc
      $error("vmac_reducer: ACC_W must hold a full product");
   end

   vmac_state_e             state_q;
   logic                    fire;
   logic                    m_valid, m_last;
   logic signed [ACC_W-1:0] m_prod;
   logic [ACC_W*ADD_STAGES-1:0] slots;
   logic                    ring_done;
   logic [ACC_W-1:0]        total;

   assign in_ready = (state_q == ST_FILL);
   assign fire     = in_valid & in_ready;

   vmac_mul_pipe #(
      .DATA_W(DATA_W), .ACC_W(ACC_W), .STAGES(MUL_STAGES)
   ) u_mul (
      .clk(clk), .rst_n(rst_n), .in_fire(fire), .in_last(in_last),
      .in_a(in_a), .in_b(in_b),
      .out_valid(m_valid), .out_last(m_last), .out_prod(m_prod)
   );

   vmac_add_ring #(
      .ACC_W(ACC_W), .STAGES(ADD_STAGES)
   ) u_ring (
      .clk(clk), .rst_n(rst_n), .clear(ring_done),
      .in_valid(m_valid), .in_last(m_last), .in_prod(m_prod),
      .slots_flat(slots), .done(ring_done)
   );

   vmac_reduce #(
      .ACC_W(ACC_W), .LANES(ADD_STAGES)
   ) u_reduce (
      .slots_flat(slots), .total(total)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_FILL;
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= ring_done;
         if (ring_done) begin
            res_data <= total;
            state_q  <= ST_FILL;
         end else if (fire && in_last) begin
            state_q  <= ST_DRAIN;
         end
      end
   end
endmodule

// File: rtl/vmac_reducer_chk.sv
module vmac_reducer_chk #(
   parameter int DATA_W     = 32,
   parameter int ACC_W      = 64,
   parameter int MUL_STAGES = 10,
   parameter int ADD_STAGES = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_last,
   input logic signed [DATA_W-1:0] in_a,
   input logic signed [DATA_W-1:0] in_b,
   input logic                     in_ready,
   input logic                     res_valid,
   input logic signed [ACC_W-1:0]  res_data
);
   localparam int LAT = MUL_STAGES + ADD_STAGES + 1;
   localparam int CW  = $clog2(LAT + 2);

   logic                    take;
   logic [CW-1:0]           win_cnt;
   logic signed [ACC_W-1:0] ref_run, ref_hold, pair_prod;

   assign take      = in_valid && in_ready;
   assign pair_prod = ACC_W'(in_a) * ACC_W'(in_b);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_cnt  <= '0;
         ref_run  <= '0;
         ref_hold <= '0;
      end else begin
         if (take && in_last) win_cnt <= CW'(1);
         else if (res_valid)  win_cnt <= '0;
         else if (win_cnt != '0) win_cnt <= win_cnt + CW'(1);
         if (take && in_last) begin
            ref_hold <= ref_run + pair_prod;
            ref_run  <= '0;
         end else if (take) begin
            ref_run  <= ref_run + pair_prod;
         end
      end
   end

   p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_data == ref_hold);
   p_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_cnt == CW'(LAT)) |-> res_valid);
   p_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (win_cnt == CW'(LAT)));
   p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_last) |=> !in_ready);
   p_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> in_ready);
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable(res_data));
endmodule

bind vmac_reducer vmac_reducer_chk #(
   .DATA_W(DATA_W), .ACC_W(ACC_W),
   .MUL_STAGES(MUL_STAGES), .ADD_STAGES(ADD_STAGES)
) u_chk (.*);

// File: tb/vmac_reducer_tb.sv
`timescale 1ns/1ps
module vmac_reducer_tb;
   localparam int NV  = 5;
   localparam int LAT = 15;

   localparam int    VLEN [NV] = '{1, 4, 5, 6, 2};
   localparam int    VA [NV][6] = '{
      '{7, 0, 0, 0, 0, 0},
      '{1, 2, 3, 4, 0, 0},
      '{-3, 10, 0, -8, 2, 0},
      '{1000, 2000, 3000, -4000, 5, 6},
      '{32'sh8000_0000, 32'sh8000_0000, 0, 0, 0, 0}};
   localparam int    VB [NV][6] = '{
      '{6, 0, 0, 0, 0, 0},
      '{5, 6, 7, 8, 0, 0},
      '{4, -5, 9, -1, 100, 0},
      '{-1, 1, 2, 3, 4, 5},
      '{32'sh8000_0000, 32'sh8000_0000, 0, 0, 0, 0}};
   localparam longint VEXP [NV] = '{
      64'sd42, 64'sd70, 64'sd146, -64'sd4950, 64'sh8000_0000_0000_0000};

   logic clk = 1'b0;
   logic rst_n;
   logic in_valid, in_last;
   logic signed [31:0] in_a, in_b;
   logic in_ready, res_valid;
   logic signed [63:0] res_data;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   vmac_reducer u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_a(in_a), .in_b(in_b), .in_ready(in_ready),
      .res_valid(res_valid), .res_data(res_data)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // gap: idle beat with junk data inside the vector (R3)
   // junk: pairs offered while in_ready is low (R6)
   task automatic run_vec(input int idx, input bit gap, input bit junk);
      for (int i = 0; i < VLEN[idx]; i++) begin
         @(negedge clk);
         if (gap && i == 2) begin
            in_valid = 1'b0; in_last = 1'b1; in_a = 32'sd999; in_b = 32'sd999;
            @(negedge clk);
         end
         check(in_ready == 1'b1, "R3 ready while streaming", longint'(in_ready), 1);
         in_valid = 1'b1;
         in_last  = (i == VLEN[idx] - 1);
         in_a     = VA[idx][i];
         in_b     = VB[idx][i];
      end
      for (int k = 1; k <= 18; k++) begin
         @(negedge clk);
         if (k == LAT) begin
            check(res_valid == 1'b1, "R4 pulse due", longint'(res_valid), 1);
            check(res_data == VEXP[idx], "R2 dot product", res_data, VEXP[idx]);
            check(in_ready == 1'b1, "R5 ready returns", longint'(in_ready), 1);
         end else begin
            check(res_valid == 1'b0, "R4 no pulse off-window", longint'(res_valid), 0);
            if (k < LAT)
               check(in_ready == 1'b0, "R5 stalled while draining", longint'(in_ready), 0);
         end
         if (k == LAT + 1)
            check(res_data == VEXP[idx], "R7 result held", res_data, VEXP[idx]);
         if (junk && k <= LAT - 2) begin
            in_valid = 1'b1; in_last = k[0];
            in_a = 32'sd12345 + k; in_b = -32'sd777;
         end else begin
            in_valid = 1'b0; in_last = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_a = '0; in_b = '0;
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R1 reset valid", longint'(res_valid), 0);
      check(res_data == 64'sd0, "R1 reset data", res_data, 0);
      check(in_ready == 1'b1, "R1 reset ready", longint'(in_ready), 1);
      rst_n = 1'b1;

      // table walk: R2, R8 (single pair, wrap), R9 (back-to-back vectors)
      for (int v = 0; v < NV; v++) begin
         run_vec(v, v == 2, v == 3);
      end

      // R1: reset mid-vector discards partial sums, then R9 clean restart
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_last = 1'b0; in_a = 32'sd50; in_b = 32'sd50;
      end
      @(negedge clk);
      in_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(in_ready == 1'b1, "R1 ready after mid-vector reset", longint'(in_ready), 1);
      check(res_valid == 1'b0, "R1 no pulse after reset", longint'(res_valid), 0);
      rst_n = 1'b1;
      run_vec(1, 1'b0, 1'b0);

      // R8: single pair of extreme magnitude
      @(negedge clk);
      in_valid = 1'b1; in_last = 1'b1;
      in_a = 32'sh7fff_ffff; in_b = 32'sh8000_0000;
      for (int k = 1; k <= LAT; k++) begin
         @(negedge clk);
         in_valid = 1'b0; in_last = 1'b0;
      end
      check(res_valid == 1'b1, "R8 single extreme pulse", longint'(res_valid), 1);
      check(res_data == -64'sd4611686016279904256, "R8 max times min",
            res_data, -64'sd4611686016279904256);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule